// File: doc/BRIEF.md
# Windowed Time-Averaged Depth Monitor

This block watches a set of buffer occupancy counters and reports how full each one was on average over fixed, back-to-back observation windows. Every clock cycle it adds the current value of each counter into a private accumulator. Because every sample covers exactly one cycle, the running sum is the integral of depth over time, expressed in depth-cycles.

A window spans `WINDOW` clock cycles. Windows are aligned to the end of reset, and the sample taken on the last cycle of a window still belongs to that window. When a window closes, each accumulated sum is divided by the window length. The result is an unsigned fixed-point value with 8 fractional bits, and the division truncates. The block then clears its accumulators and starts the next window at once. The averages leave the block as a valid/ready stream, one record per counter in ascending index order. Every record in a batch carries the same timestamp: the number of cycles from the end of reset to the end of that window.

While records wait for the consumer, the accumulators keep integrating the following window. The block stores only one batch of results. If a window closes while any record of the previous batch is still unaccepted, the newly closed window produces no records. Its accumulators are still cleared, and its timestamp is still consumed.

Top module: `win_depth_avg`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `rec_valid` is low, and all accumulators and the cycle count start from zero.
- R2: On every cycle after reset, each counter contributes its present depth value, weighted by one cycle, to the sum of the window in progress.
- R3: Window k (k = 1, 2, ...) closes on the edge that ends cycle k*`WINDOW` after reset. Its records carry `rec_time` = k*`WINDOW`, so a valid timestamp is never zero and is always a multiple of `WINDOW`.
- R4: `rec_avg` equals floor(sum * 256 / `WINDOW`): integer part in the upper bits, 8 fractional bits in bits [7:0].
- R5: When a window closes, its accumulators are cleared, so a window's averages depend only on samples taken inside it.
- R6: A batch consists of `NUM_CNT` records with `rec_idx` 0, 1, ..., `NUM_CNT`-1 in that order. The first record of the batch appears on the cycle after the window closes.
- R7: While `rec_valid` is high and `rec_ready` is low, the record fields stay unchanged on the next cycle.
- R8: Stalling the output stream never pauses integration. The windows that follow a stall report exact averages.
- R9: A window that closes while a previous record is still unaccepted yields no records. A batch counts as drained if its last record is accepted on the same closing edge, and in that case the new batch is loaded without a gap.
- R10: When every depth holds its maximum value for a whole window, the average is that maximum times 256, with no overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| depth_vec | input | NUM_CNT*DEPTH_W | Packed depth counters; counter i occupies bits [i*DEPTH_W +: DEPTH_W] |
| rec_valid | output | 1 | A record is offered |
| rec_ready | input | 1 | Consumer accepts the offered record |
| rec_time | output | TS_W | Cycles from end of reset to the end of the window |
| rec_idx | output | max(1,clog2(NUM_CNT)) | Counter index of the record |
| rec_avg | output | DEPTH_W+8 | Time-averaged depth, 8 fractional bits |

## Verification
The bench builds the block with four 4-bit counters and a 6-cycle window. Because 256 is not a multiple of 6, truncation of the fractional part is exercised. A single batch drains in four cycles, so stalls of 15 cycles span whole windows, and the dropped-window path and integration during a stall both come within reach. A full window at depth 15 hits the widest possible sum. A zero window that follows it shows whether the accumulators were cleared.

// File: rtl/wda_pkg.sv
package wda_pkg;

    localparam int FRAC_W = 8;

    typedef enum logic {
        EM_IDLE = 1'b0,
        EM_SEND = 1'b1
    } em_state_t;

    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/depth_integrator.sv
module depth_integrator #(
    parameter int DEPTH_W = 4,
    parameter int ACC_W   = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [DEPTH_W-1:0] depth_in,
    input  logic               close_i,
    output logic [ACC_W-1:0]   sum_o
);

    logic [ACC_W-1:0] acc_q;

    // Sum including the present sample; this is the closing value on a boundary.
    assign sum_o = acc_q + ACC_W'(depth_in);

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
        end else if (close_i) begin
            acc_q <= '0;
        end else begin
            acc_q <= sum_o;
        end
    end

endmodule

// File: rtl/window_timer.sv
module window_timer #(
    parameter int WINDOW = 64,
    parameter int WC_W   = 7,
    parameter int TS_W   = 32
) (
    input  logic            clk,
    input  logic            rst,
    output logic            boundary_o,
    output logic [TS_W-1:0] ts_end_o
);

    logic [WC_W-1:0] win_q;
    logic [TS_W-1:0] ts_q;

    assign boundary_o = (win_q == WC_W'(WINDOW - 1));
    assign ts_end_o   = ts_q + TS_W'(WINDOW);

    always_ff @(posedge clk) begin
        if (rst) begin
            win_q <= '0;
            ts_q  <= '0;
        end else if (boundary_o) begin
            win_q <= '0;
            ts_q  <= ts_end_o;
        end else begin
            win_q <= win_q + WC_W'(1);
        end
    end

endmodule

// File: rtl/record_emitter.sv
module record_emitter
    import wda_pkg::*;
#(
    parameter int NUM_CNT = 4,
    parameter int AVG_W   = 12,
    parameter int TS_W    = 32,
    parameter int IDX_W   = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     load_req,
    input  logic [NUM_CNT*AVG_W-1:0] avg_flat,
    input  logic [TS_W-1:0]          ts_in,
    input  logic                     ready_i,
    output logic                     valid_o,
    output logic [IDX_W-1:0]         idx_o,
    output logic [AVG_W-1:0]         avg_o,
    output logic [TS_W-1:0]          ts_o
);

    em_state_t        state_q;
    logic [IDX_W-1:0] idx_q;
    logic [TS_W-1:0]  ts_q;
    logic [AVG_W-1:0] bank_q [NUM_CNT];

    logic sending, last, fire, free, load;

    assign sending = (state_q == EM_SEND);
    assign last    = sending && (idx_q == IDX_W'(NUM_CNT - 1));
    assign fire    = sending && ready_i;
    // The bank may be refilled on the edge that accepts its final record.
    assign free    = !sending || (fire && last);
    assign load    = load_req && free;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= EM_IDLE;
            idx_q   <= '0;
            ts_q    <= '0;
        end else if (load) begin
            state_q <= EM_SEND;
            idx_q   <= '0;
            ts_q    <= ts_in;
        end else if (fire) begin
            if (last) begin
                state_q <= EM_IDLE;
            end else begin
                idx_q <= idx_q + IDX_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (load) begin
            for (int k = 0; k < NUM_CNT; k++) begin
                bank_q[k] <= avg_flat[k*AVG_W +: AVG_W];
            end
        end
    end

    assign valid_o = sending;
    assign idx_o   = idx_q;
    assign avg_o   = bank_q[idx_q];
    assign ts_o    = ts_q;

endmodule

// File: rtl/win_depth_avg.sv
module win_depth_avg
    import wda_pkg::*;
#(
    parameter int NUM_CNT = 4,
    parameter int DEPTH_W = 4,
    parameter int WINDOW  = 64,
    parameter int TS_W    = 32
) (
    input  logic                                     clk,
    input  logic                                     rst,
    input  logic [NUM_CNT*DEPTH_W-1:0]               depth_vec,
    output logic                                     rec_valid,
    input  logic                                     rec_ready,
    output logic [TS_W-1:0]                          rec_time,
    output logic [((NUM_CNT > 1) ? $clog2(NUM_CNT) : 1)-1:0] rec_idx,
    output logic [DEPTH_W+FRAC_W-1:0]                rec_avg
);

    localparam int IDX_W = idx_width(NUM_CNT);
    localparam int ACC_W = DEPTH_W + $clog2(WINDOW + 1);
    localparam int AVG_W = DEPTH_W + FRAC_W;
    localparam int DIV_W = ACC_W + FRAC_W;
    localparam int WC_W  = $clog2(WINDOW + 1);

    logic                     boundary;
    logic [TS_W-1:0]          ts_end;
    logic [NUM_CNT*AVG_W-1:0] avg_flat;

    window_timer #(
        .WINDOW (WINDOW),
        .WC_W   (WC_W),
        .TS_W   (TS_W)
    ) u_timer (
        .clk        (clk),
        .rst        (rst),
        .boundary_o (boundary),
        .ts_end_o   (ts_end)
    );

    for (genvar g = 0; g < NUM_CNT; g++) begin : g_lane
        logic [ACC_W-1:0] sum_w;
        logic [DIV_W-1:0] scaled_w;
        logic [DIV_W-1:0] quot_w;

        depth_integrator #(
            .DEPTH_W (DEPTH_W),
            .ACC_W   (ACC_W)
        ) u_int (
            .clk      (clk),
            .rst      (rst),
            .depth_in (depth_vec[g*DEPTH_W +: DEPTH_W]),
            .close_i  (boundary),
            .sum_o    (sum_w)
        );

        // Truncating division by the constant window length.
        assign scaled_w = {sum_w, {FRAC_W{1'b0}}};
        assign quot_w   = scaled_w / DIV_W'(WINDOW);
        assign avg_flat[g*AVG_W +: AVG_W] = AVG_W'(quot_w);
    end

    record_emitter #(
        .NUM_CNT (NUM_CNT),
        .AVG_W   (AVG_W),
        .TS_W    (TS_W),
        .IDX_W   (IDX_W)
    ) u_emit (
        .clk      (clk),
        .rst      (rst),
        .load_req (boundary),
        .avg_flat (avg_flat),
        .ts_in    (ts_end),
        .ready_i  (rec_ready),
        .valid_o  (rec_valid),
        .idx_o    (rec_idx),
        .avg_o    (rec_avg),
        .ts_o     (rec_time)
    );

endmodule

// File: rtl/win_depth_avg_chk.sv
module win_depth_avg_chk #(
    parameter int NUM_CNT = 4,
    parameter int DEPTH_W = 4,
    parameter int WINDOW  = 64,
    parameter int TS_W    = 32,
    parameter int IDX_W   = 2,
    parameter int AVG_W   = 12
) (
    input logic             clk,
    input logic             rst,
    input logic             rec_valid,
    input logic             rec_ready,
    input logic [TS_W-1:0]  rec_time,
    input logic [IDX_W-1:0] rec_idx,
    input logic [AVG_W-1:0] rec_avg
);

    localparam logic [AVG_W-1:0] MAX_AVG = AVG_W'(((1 << DEPTH_W) - 1) << (AVG_W - DEPTH_W));

    // R7: an offered record is held while the consumer stalls
    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (rec_valid && !rec_ready) |=> (rec_valid && $stable(rec_idx) && $stable(rec_avg) && $stable(rec_time)));

    // R6: indices advance by one within a batch
    p_order_r6: assert property (@(posedge clk) disable iff (rst)
        (rec_valid && rec_ready && rec_idx != IDX_W'(NUM_CNT - 1)) |=> (rec_valid && rec_idx == $past(rec_idx) + IDX_W'(1)));

    // R6: a batch starts at index zero
    p_start_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(rec_valid) |-> (rec_idx == '0));

    // R3: timestamps are nonzero multiples of the window length
    p_ts_r3: assert property (@(posedge clk) disable iff (rst)
        rec_valid |-> (rec_time != '0 && (rec_time % TS_W'(WINDOW)) == '0));

    // R10: an average never exceeds the maximum depth
    p_range_r10: assert property (@(posedge clk) disable iff (rst)
        rec_valid |-> (rec_avg <= MAX_AVG));

endmodule

bind win_depth_avg win_depth_avg_chk #(
    .NUM_CNT (NUM_CNT),
    .DEPTH_W (DEPTH_W),
    .WINDOW  (WINDOW),
    .TS_W    (TS_W),
    .IDX_W   (IDX_W),
    .AVG_W   (AVG_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .rec_valid (rec_valid),
    .rec_ready (rec_ready),
    .rec_time  (rec_time),
    .rec_idx   (rec_idx),
    .rec_avg   (rec_avg)
);

// File: tb/sim_win_depth_avg.sv
`timescale 1ns/1ps
module sim_win_depth_avg;

    localparam int N    = 4;
    localparam int DW   = 4;
    localparam int W    = 6;
    localparam int MAXD = (1 << DW) - 1;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [N*DW-1:0]   depth_vec = '0;
    logic              rec_ready = 1'b0;
    logic              rec_valid;
    logic [31:0]       rec_time;
    logic [1:0]        rec_idx;
    logic [DW+7:0]     rec_avg;

    always #10 clk = ~clk;

    win_depth_avg #(.NUM_CNT(N), .DEPTH_W(DW), .WINDOW(W), .TS_W(32)) u0 (
        .clk(clk), .rst(rst), .depth_vec(depth_vec), .rec_valid(rec_valid),
        .rec_ready(rec_ready), .rec_time(rec_time), .rec_idx(rec_idx), .rec_avg(rec_avg)
    );

    typedef struct { int ts; int idx; int avg; } rec_t;
    rec_t q[$];

    int checks = 0;
    int fails  = 0;
    int acc [N];
    int wcnt = 0;
    int tsm  = 0;
    string tag = "R4";
    bit done = 1'b0;
    bit pv = 1'b0, pr = 1'b0;
    int pts = 0, pidx = 0, pavg = 0;

    function automatic int exp_avg(input int sum);
        return (sum * 256) / W;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_outputs();
        chk("R9 valid", int'(rec_valid), (q.size() > 0) ? 1 : 0);
        if (rec_valid && q.size() > 0) begin
            chk("R3 time", int'(rec_time), q[0].ts);
            chk("R6 idx", int'(rec_idx), q[0].idx);
            chk({tag, " avg"}, int'(rec_avg), q[0].avg);
        end
        if (pv && !pr) begin
            // R7: held fields during a stall
            chk("R7 hold", int'(rec_valid), 1);
            chk("R7 hold time", int'(rec_time), pts);
            chk("R7 hold idx", int'(rec_idx), pidx);
            chk("R7 hold avg", int'(rec_avg), pavg);
        end
        pv = rec_valid; pts = int'(rec_time); pidx = int'(rec_idx); pavg = int'(rec_avg);
    endtask

    task automatic drive_and_model(input bit rdy, input int mode);
        int d [N];
        for (int i = 0; i < N; i++) begin
            if (mode == 0) d[i] = 0;
            else if (mode == 1) d[i] = MAXD;
            else d[i] = int'($urandom_range(0, MAXD));
            depth_vec[i*DW +: DW] = DW'(d[i]);
        end
        rec_ready = rdy;
        pr = rdy;
        if (rdy && q.size() > 0) void'(q.pop_front());
        for (int i = 0; i < N; i++) acc[i] += d[i];   // R2
        if (wcnt == W - 1) begin
            tsm += W;
            if (q.size() == 0) begin
                for (int i = 0; i < N; i++) q.push_back('{tsm, i, exp_avg(acc[i])});
            end
            for (int i = 0; i < N; i++) acc[i] = 0;   // R5
            wcnt = 0;
        end else begin
            wcnt++;
        end
    endtask

    task automatic cycle(input bit rdy, input int mode);
        @(negedge clk);
        check_outputs();
        drive_and_model(rdy, mode);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < N; i++) acc[i] = 0;
        repeat (3) @(negedge clk);
        chk("R1 reset valid", int'(rec_valid), 0);
        @(negedge clk);
        chk("R1 reset valid", int'(rec_valid), 0);
        rst = 1'b0;
        drive_and_model(1'b1, 1);
        tag = "R10";
        for (int c = 0; c < 3*W; c++) cycle(1'b1, 1);
        tag = "R5";
        for (int c = 0; c < 3*W; c++) cycle(1'b1, 0);
        tag = "R2";
        for (int c = 0; c < 200; c++) cycle(1'b1, 2);
        tag = "R4";
        for (int c = 0; c < 400; c++) cycle(($urandom_range(0, 9) < 6), 2);
        tag = "R8";
        for (int r = 0; r < 12; r++) begin
            for (int c = 0; c < 15; c++) cycle(1'b0, 2);
            for (int c = 0; c < 10 + r; c++) cycle(1'b1, 2);
        end
        tag = "R4";
        for (int c = 0; c < 300; c++) cycle(($urandom_range(0, 9) < 8), 2);
        for (int c = 0; c < 3*W; c++) cycle(1'b1, 0);
        @(negedge clk);
        check_outputs();
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog R6 actual=running expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule